// File: doc/BRIEF.md
# Flag-Offset Readback Sequencer

This block lets the read side of a FIFO fetch the stored almost-empty and almost-full threshold offsets through the ordinary data output bus. Each offset is wider than the bus, so it is presented as a short series of bus-width words. One word is delivered for every read-clock edge on which both the active-low load-select and the active-low read-enable are asserted. An internal word index records which word comes next.

The same output register also carries FIFO data. The block owns this register. It decides on each edge whether the register takes a readback word, a FIFO word, or holds. It drives the FIFO's read strobe, so that a readback step never consumes a FIFO entry. The readback can be interrupted at any point by ordinary FIFO traffic. When it resumes, it continues from the word where it stopped. A readback word overwrites whatever FIFO word was in the output register.

The block supports both standard read timing and first-word-fall-through timing, and the readback behaves the same in either one. A master reset (asynchronous) or a partial reset (synchronous) returns the index to the first word.

Top module: `rb_top`

## Requirements
- R1: After the asynchronous reset `rst_ni`, `q_o`, `q_valid_o`, `sel_offset_o` and `fifo_rd_en_o` are 0, and the next readback step returns the first almost-empty word.
- R2: A readback step happens only on a rising `clk_i` edge where `ld_ni`=0, `ren_ni`=0 and `part_rst_i`=0. With `ld_ni`=0 and `ren_ni`=1, `q_o` holds and the index does not move.
- R3: The readback order is all almost-empty words first, then all almost-full words. Word k of an offset is bits [k*DW +: DW], with bits above OFFW read as 0. Words per offset = ceil(OFFW/DW).
- R4: The step after the last almost-full word returns the first almost-empty word again.
- R5: While `ld_ni` or `ren_ni` is deasserted, the index holds. After any interleaved FIFO reads, the next step continues with the next unread word.
- R6: In standard mode, with `ld_ni`=1, `ren_ni`=0 and `fifo_empty_i`=0, `fifo_rd_en_o` is 1 and the edge loads `fifo_rdata_i` into `q_o`.
- R7: A readback step never asserts `fifo_rd_en_o` and never changes `q_valid_o`.
- R8: `part_rst_i`=1 on an edge returns the index to the first word and clears `q_valid_o`. No step and no FIFO read happens on that edge.
- R9: In first-word-fall-through mode (`fwft_i`=1), when `q_valid_o`=0, `ld_ni`=1 and `fifo_empty_i`=0, the head word loads without `ren_ni`. Readback steps give the same word sequence as in standard mode.
- R10: `sel_offset_o` is 1 after a readback step and returns to 0 when a FIFO word is next loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| part_rst_i | input | 1 | Synchronous partial reset, active high |
| fwft_i | input | 1 | 1 = first-word-fall-through timing, 0 = standard |
| ld_ni | input | 1 | Load-select, active low |
| ren_ni | input | 1 | Read enable, active low |
| fifo_empty_i | input | 1 | FIFO storage holds no word |
| fifo_rdata_i | input | DW | Head word from FIFO storage |
| ae_off_i | input | OFFW | Almost-empty offset value |
| af_off_i | input | OFFW | Almost-full offset value |
| q_o | output | DW | Shared data output register |
| q_valid_o | output | 1 | Output register holds a FIFO word |
| sel_offset_o | output | 1 | Output register was last loaded by a readback step |
| fifo_rd_en_o | output | 1 | Read strobe to the FIFO read pointer |

## Verification
The readback is driven as an unbroken run of steps that crosses the wrap point. This separates a correct word order from swapped offsets, a reversed word order within an offset, and a missing wrap. Runs are also interrupted by normal reads, by a deasserted read-enable alone, and by a partial reset. These show whether the index resumes, holds, or restarts, and whether FIFO data and the read strobe stay apart from readback steps. The same runs are repeated in fall-through mode to show that the timing mode does not change the word sequence.

// File: rtl/rb_pkg.sv
`timescale 1ns/1ps
package rb_pkg;
  function automatic int words_per(input int ow, input int dw);
    return (ow + dw - 1) / dw;
  endfunction
endpackage

// File: rtl/rb_index_ctr.sv
`timescale 1ns/1ps
module rb_index_ctr #(
  parameter int NW = 4,
  parameter int IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [IW-1:0] idx_o
);
  localparam logic [IW-1:0] LAST = IW'(NW - 1);
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (clr_i)    idx_q <= '0;
    else if (adv_i)    idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/rb_word_mux.sv
`timescale 1ns/1ps
module rb_word_mux #(
  parameter int DW   = 9,
  parameter int OFFW = 16,
  parameter int WPO  = 2,
  parameter int IW   = 2
) (
  input  logic [OFFW-1:0] ae_i,
  input  logic [OFFW-1:0] af_i,
  input  logic [IW-1:0]   idx_i,
  output logic [DW-1:0]   word_o
);
  localparam int PW   = WPO * DW;
  localparam int SLOT = 1 << IW;

  logic [PW-1:0] ae_pad, af_pad;
  logic [DW-1:0] words [SLOT];

  always_comb begin
    ae_pad = '0;
    af_pad = '0;
    ae_pad[OFFW-1:0] = ae_i;
    af_pad[OFFW-1:0] = af_i;
  end

  for (genvar k = 0; k < SLOT; k++) begin : g_slot
    if (k < WPO) begin : g_ae
      assign words[k] = ae_pad[k*DW +: DW];
    end else if (k < 2*WPO) begin : g_af
      assign words[k] = af_pad[(k-WPO)*DW +: DW];
    end else begin : g_unused
      assign words[k] = '0;
    end
  end

  assign word_o = words[idx_i];
endmodule

// File: rtl/rb_out_ctl.sv
`timescale 1ns/1ps
module rb_out_ctl #(
  parameter int DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          fwft_i,
  input  logic          ld_ni,
  input  logic          ren_ni,
  input  logic          empty_i,
  input  logic          step_i,
  input  logic [DW-1:0] rb_word_i,
  input  logic [DW-1:0] fifo_word_i,
  output logic [DW-1:0] q_o,
  output logic          valid_o,
  output logic          sel_o,
  output logic          rd_en_o
);
  logic [DW-1:0] q_q;
  logic          valid_q, sel_q, consume;

  // FIFO side advances on a plain read, or on fall-through into an empty output
  always_comb begin
    consume = ld_ni & ~clr_i & (~ren_ni | (fwft_i & ~valid_q));
    rd_en_o = consume & ~empty_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q     <= '0;
      valid_q <= 1'b0;
      sel_q   <= 1'b0;
    end else if (clr_i) begin
      valid_q <= 1'b0;
    end else if (step_i) begin
      q_q   <= rb_word_i;
      sel_q <= 1'b1;
    end else if (consume) begin
      valid_q <= ~empty_i;
      if (!empty_i) begin
        q_q   <= fifo_word_i;
        sel_q <= 1'b0;
      end
    end
  end

  assign q_o     = q_q;
  assign valid_o = valid_q;
  assign sel_o   = sel_q;
endmodule

// File: rtl/rb_top.sv
`timescale 1ns/1ps
module rb_top #(
  parameter int DW   = 9,
  parameter int OFFW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            part_rst_i,
  input  logic            fwft_i,
  input  logic            ld_ni,
  input  logic            ren_ni,
  input  logic            fifo_empty_i,
  input  logic [DW-1:0]   fifo_rdata_i,
  input  logic [OFFW-1:0] ae_off_i,
  input  logic [OFFW-1:0] af_off_i,
  output logic [DW-1:0]   q_o,
  output logic            q_valid_o,
  output logic            sel_offset_o,
  output logic            fifo_rd_en_o
);
  localparam int WPO = rb_pkg::words_per(OFFW, DW);
  localparam int NW  = 2 * WPO;
  localparam int IW  = $clog2(NW);

  logic          step;
  logic [IW-1:0] idx;
  logic [DW-1:0] rb_word;

  assign step = ~ld_ni & ~ren_ni & ~part_rst_i;

  rb_index_ctr #(.NW(NW), .IW(IW)) u_idx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (part_rst_i),
    .adv_i (step),
    .idx_o (idx)
  );

  rb_word_mux #(.DW(DW), .OFFW(OFFW), .WPO(WPO), .IW(IW)) u_mux (
    .ae_i  (ae_off_i),
    .af_i  (af_off_i),
    .idx_i (idx),
    .word_o(rb_word)
  );

  rb_out_ctl #(.DW(DW)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (part_rst_i),
    .fwft_i     (fwft_i),
    .ld_ni      (ld_ni),
    .ren_ni     (ren_ni),
    .empty_i    (fifo_empty_i),
    .step_i     (step),
    .rb_word_i  (rb_word),
    .fifo_word_i(fifo_rdata_i),
    .q_o        (q_o),
    .valid_o    (q_valid_o),
    .sel_o      (sel_offset_o),
    .rd_en_o    (fifo_rd_en_o)
  );
endmodule

// File: rtl/rb_chk.sv
`timescale 1ns/1ps
module rb_chk #(
  parameter int DW = 9,
  parameter int NW = 4,
  parameter int IW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          part_rst_i,
  input logic          ld_ni,
  input logic          ren_ni,
  input logic [IW-1:0] idx,
  input logic [DW-1:0] q_o,
  input logic          q_valid_o,
  input logic          sel_offset_o,
  input logic          fifo_rd_en_o
);
  localparam logic [IW-1:0] LAST = IW'(NW - 1);
  logic stp;
  assign stp = ~ld_ni & ~ren_ni & ~part_rst_i;

  assert_step_no_fifo_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_ni && !ren_ni) |-> !fifo_rd_en_o);
  assert_step_keeps_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stp |=> $stable(q_valid_o));
  assert_pause_holds_index_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stp && !part_rst_i) |=> $stable(idx));
  assert_step_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stp && idx != LAST) |=> idx == $past(idx) + 1'b1);
  assert_wrap_to_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stp && idx == LAST) |=> idx == '0);
  assert_partial_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    part_rst_i |=> (idx == '0 && !q_valid_o));
  assert_sel_after_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stp |=> sel_offset_o);
  assert_q_holds_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stp && !fifo_rd_en_o) |=> $stable(q_o));
endmodule

bind rb_top rb_chk #(.DW(DW), .NW(NW), .IW(IW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .part_rst_i  (part_rst_i),
  .ld_ni       (ld_ni),
  .ren_ni      (ren_ni),
  .idx         (idx),
  .q_o         (q_o),
  .q_valid_o   (q_valid_o),
  .sel_offset_o(sel_offset_o),
  .fifo_rd_en_o(fifo_rd_en_o)
);

// File: tb/sim_rb_top.sv
`timescale 1ns/1ps
module sim_rb_top;
  localparam int DW   = 9;
  localparam int OFFW = 16;
  localparam int WPO  = (OFFW + DW - 1) / DW;
  localparam int NW   = 2 * WPO;

  logic            clk_i = 1'b0;
  logic            rst_ni, part_rst_i, fwft_i, ld_ni, ren_ni, fifo_empty_i;
  logic [DW-1:0]   fifo_rdata_i;
  logic [OFFW-1:0] ae_off_i, af_off_i;
  logic [DW-1:0]   q_o;
  logic            q_valid_o, sel_offset_o, fifo_rd_en_o;

  int n_tests = 0, n_fail = 0, exp_idx = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  rb_top #(.DW(DW), .OFFW(OFFW)) u0 (.*);

  function automatic logic [DW-1:0] exp_word(int i);
    logic [OFFW-1:0] src;
    int k;
    src = (i < WPO) ? ae_off_i : af_off_i;
    k   = (i < WPO) ? i : i - WPO;
    return DW'(32'(src) >> (k * DW));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic idle();
    ld_ni = 1; ren_ni = 1; part_rst_i = 0;
  endtask

  task automatic do_reset(bit fw);
    idle(); fwft_i = fw; fifo_empty_i = 1; fifo_rdata_i = '0;
    rst_ni = 0; #10; rst_ni = 1; tick(); exp_idx = 0;
  endtask

  task automatic rb_step(string req);
    ld_ni = 0; ren_ni = 0; #1;
    check({req, " no fifo read"}, 32'(fifo_rd_en_o), 0);
    tick();
    check(req, 32'(q_o), 32'(exp_word(exp_idx)));
    check({req, " sel"}, 32'(sel_offset_o), 1);
    exp_idx = (exp_idx + 1) % NW;
    idle();
  endtask

  task automatic t_reset();
    rst_ni = 1; #2; rst_ni = 0; #2;
    check("R1 q", 32'(q_o), 0);
    check("R1 valid", 32'(q_valid_o), 0);
    check("R1 sel", 32'(sel_offset_o), 0);
    check("R1 rd_en", 32'(fifo_rd_en_o), 0);
    rst_ni = 1; tick(); exp_idx = 0;
    rb_step("R1 first word");
  endtask

  task automatic t_order_wrap();
    do_reset(0);
    fifo_empty_i = 0;
    for (int i = 0; i < NW; i++) rb_step("R3 order");
    rb_step("R4 wrap");
    rb_step("R4 after wrap");
  endtask

  task automatic t_pause_resume();
    logic [DW-1:0] held;
    do_reset(0);
    rb_step("R2 step");
    ld_ni = 0; ren_ni = 1; fifo_empty_i = 0; fifo_rdata_i = 9'h0A5; #1;
    held = q_o;
    check("R2 rd_en paused", 32'(fifo_rd_en_o), 0);
    tick(); tick();
    check("R2 q held", 32'(q_o), 32'(held));
    idle(); ren_ni = 0; #1;
    check("R6 rd_en", 32'(fifo_rd_en_o), 1);
    tick();
    check("R6 fifo word", 32'(q_o), 32'h0A5);
    check("R10 sel cleared", 32'(sel_offset_o), 0);
    check("R6 valid", 32'(q_valid_o), 1);
    fifo_rdata_i = 9'h13C; tick();
    check("R6 second word", 32'(q_o), 32'h13C);
    idle(); tick();
    rb_step("R5 resume");
    check("R7 valid kept", 32'(q_valid_o), 1);
    rb_step("R5 resume next");
  endtask

  task automatic t_partial();
    do_reset(0);
    fifo_empty_i = 0; fifo_rdata_i = 9'h055;
    ren_ni = 0; tick(); idle();
    rb_step("R8 pre");
    rb_step("R8 pre2");
    ld_ni = 0; ren_ni = 0; part_rst_i = 1; #1;
    check("R8 rd_en blocked", 32'(fifo_rd_en_o), 0);
    tick();
    check("R8 valid cleared", 32'(q_valid_o), 0);
    check("R8 no step", 32'(q_o), 32'(exp_word(1)));
    idle(); exp_idx = 0;
    rb_step("R8 restart");
  endtask

  task automatic t_fwft();
    do_reset(1);
    fifo_empty_i = 0; fifo_rdata_i = 9'h1E1; #1;
    check("R9 fall-through rd_en", 32'(fifo_rd_en_o), 1);
    tick();
    check("R9 head word", 32'(q_o), 32'h1E1);
    check("R9 valid", 32'(q_valid_o), 1);
    check("R9 no extra rd", 32'(fifo_rd_en_o), 0);
    for (int i = 0; i < NW + 1; i++) rb_step("R9 sequence");
    check("R7 fwft valid", 32'(q_valid_o), 1);
  endtask

  initial begin
    ae_off_i = 16'hA5C3; af_off_i = 16'h3B7E;
    idle(); fwft_i = 0; fifo_empty_i = 1; fifo_rdata_i = '0; rst_ni = 1;
    t_reset();
    t_order_wrap();
    t_pause_resume();
    t_partial();
    ae_off_i = 16'h0101; af_off_i = 16'hFE02;
    t_fwft();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule